// File: doc/BRIEF.md
# Flow Control Credit Protocol Checker

This block sits beside the receive side of a link's data link layer and inspects every decoded flow-control DLLP that the link partner sends. For each of the three traffic classes (posted, non-posted, completion) it keeps a header-credit limit and a data-credit limit. It compares every new advertisement against the credits the local transmitter has already consumed. If an advertisement breaks the credit rules, the block raises a one-cycle protocol error pulse. The pulse is link-wide, not tied to any single function, and feeds the uncorrectable error status logic.

Two rules are checked. The first is a ceiling: the partner may never leave the transmitter holding more than half the credit counter range as unused credit. The counter ranges are 12 bits for data and 8 bits for headers. The second is a floor: an initialisation advertisement for posted or completion traffic must offer at least 128 bytes of payload, which is 8 data credits of 16 bytes each. An initialisation value of zero means infinite credit. It is exempt from both rules, and the field it names stays infinite until reset, so later updates to that field are neither checked nor stored.

Top module: `fc_credit_checker`

## Requirements
- R1: During reset and in the first cycle after it, `fc_err` is 0. Reset clears every stored limit and every infinite-credit marking, so after a reset an update DLLP to a field that was infinite is checked again.
- R2: A DLLP whose data field is nonzero raises an error when (advertised − consumed) modulo 4096 exceeds 2047. Exactly 2047 is legal. The wrap-around case is computed the same way.
- R3: A DLLP whose header field is nonzero raises an error when (advertised − consumed) modulo 256 exceeds 127. Exactly 127 is legal. The rule applies to both initialisation and update DLLPs.
- R4: An initialisation DLLP for the posted class (class code 0) with a data value from 1 to 7 raises an error. A value of 8 does not. Both initialisation kind codes (0 and 1) are checked.
- R5: An initialisation DLLP for the completion class (class code 2) with a data value from 1 to 7 raises an error. A value of 8 does not.
- R6: The non-posted class (class code 1) has no minimum payload rule. An initialisation DLLP there with a data value from 1 to 7 raises no error.
- R7: An initialisation DLLP with a field value of 0 raises no error for that field. That field is then infinite: update DLLPs (kind code 2) to it raise no ceiling error.
- R8: `fc_err` rises exactly one cycle after the strobe of an offending DLLP and lasts one cycle. It never rises without a strobe in the previous cycle.
- R9: The six limit fields are independent. Marking one class infinite does not exempt another class.
- R10: The kind code 3 and the class code 3 are ignored: such DLLPs never raise an error.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dllp_valid | input | 1 | One-cycle strobe for a decoded flow-control DLLP |
| dllp_kind | input | 2 | 0 and 1 are initialisation, 2 is update, 3 is ignored |
| dllp_class | input | 2 | 0 is posted, 1 is non-posted, 2 is completion, 3 is ignored |
| hdr_credit | input | HDR_W (8) | Advertised header credit limit |
| data_credit | input | DATA_W (12) | Advertised data credit limit |
| tx_hdr_used | input | 3*HDR_W | Consumed header credits; slice c*HDR_W holds class c |
| tx_data_used | input | 3*DATA_W | Consumed data credits; slice c*DATA_W holds class c |
| fc_err | output | 1 | Registered one-cycle protocol error pulse |

## Verification
The bound assertions check on every cycle the timing properties: the pulse only ever follows a strobe and lasts one cycle, and an ignored kind or class never leads to a pulse. They also check the stateless rules: the posted and completion floors and the data ceiling on initialisation. Behaviour that depends on stored state can only be shown by the bench's scenarios. This covers the infinite-credit marking, its independence across classes, its removal by reset, and the modulo wrap of the outstanding-credit difference against nonzero consumed counts.

// File: rtl/fcc_pkg.sv
package fcc_pkg;

    localparam int NUM_CLASS     = 3;
    localparam int DEF_HDR_W     = 8;
    localparam int DEF_DATA_W    = 12;
    localparam int DEF_MIN_DATA  = 8;   // 8 credits x 16 bytes = 128 bytes

    typedef enum logic [1:0] {
        FC_INIT1  = 2'b00,
        FC_INIT2  = 2'b01,
        FC_UPDATE = 2'b10,
        FC_NONE   = 2'b11
    } fc_kind_e;

    typedef enum logic [1:0] {
        CL_POST    = 2'b00,
        CL_NONPOST = 2'b01,
        CL_CPL     = 2'b10,
        CL_RSVD    = 2'b11
    } fc_class_e;

    typedef struct packed {
        logic hit;      // a valid DLLP addresses this class
        logic is_init;  // it is an initialisation advertisement
    } fc_req_t;

    function automatic logic kind_is_init(input logic [1:0] k);
        return (k == FC_INIT1) || (k == FC_INIT2);
    endfunction

    function automatic logic kind_is_live(input logic [1:0] k);
        return k != FC_NONE;
    endfunction

    function automatic bit class_has_floor(input int c);
        return (c == int'(CL_POST)) || (c == int'(CL_CPL));
    endfunction

endpackage

// File: rtl/fcc_decode.sv
module fcc_decode
    import fcc_pkg::*;
(
    input  logic                          valid,
    input  logic [1:0]                    kind,
    input  logic [1:0]                    cls,
    output fc_req_t [NUM_CLASS-1:0]       req
);

    logic live;
    logic init;

    always_comb begin
        live = valid && kind_is_live(kind);
        init = kind_is_init(kind);
    end

    for (genvar c = 0; c < NUM_CLASS; c++) begin : g_cls
        always_comb begin
            req[c].hit     = live && (cls == 2'(c));
            req[c].is_init = live && (cls == 2'(c)) && init;
        end
    end

endmodule

// File: rtl/fcc_field.sv
module fcc_field
    import fcc_pkg::*;
#(
    parameter int W       = 12,
    parameter bit MIN_EN  = 1'b0,
    parameter int MIN_LIM = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  fc_req_t       req,
    input  logic [W-1:0]  adv,
    input  logic [W-1:0]  used,
    output logic          viol
);

    localparam logic [W-1:0] CEIL  = W'((1 << (W - 1)) - 1);
    localparam logic [W-1:0] FLOOR = W'(MIN_LIM);

    logic [W-1:0] lim_q;
    logic         armed_q;   // an initialisation has been seen since reset

    logic         infinite;
    logic         adv_zero;
    logic         exempt;
    logic [W-1:0] outstanding;
    logic         ceil_bad;
    logic         floor_bad;

    always_comb begin
        infinite    = armed_q && (lim_q == '0);
        adv_zero    = (adv == '0);
        exempt      = (req.is_init && adv_zero) || (!req.is_init && infinite);
        outstanding = adv - used;            // wraps modulo 2**W
        ceil_bad    = req.hit && !exempt && (outstanding > CEIL);
        floor_bad   = MIN_EN && req.is_init && !adv_zero && (adv < FLOOR);
        viol        = ceil_bad || floor_bad;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lim_q   <= '0;
            armed_q <= 1'b0;
        end else if (req.hit) begin
            if (req.is_init) begin
                lim_q   <= adv;
                armed_q <= 1'b1;
            end else if (!infinite) begin
                lim_q   <= adv;
            end
        end
    end

endmodule

// File: rtl/fc_credit_checker.sv
module fc_credit_checker
    import fcc_pkg::*;
#(
    parameter int HDR_W    = DEF_HDR_W,
    parameter int DATA_W   = DEF_DATA_W,
    parameter int MIN_DATA = DEF_MIN_DATA
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        dllp_valid,
    input  logic [1:0]                  dllp_kind,
    input  logic [1:0]                  dllp_class,
    input  logic [HDR_W-1:0]            hdr_credit,
    input  logic [DATA_W-1:0]           data_credit,
    input  logic [NUM_CLASS*HDR_W-1:0]  tx_hdr_used,
    input  logic [NUM_CLASS*DATA_W-1:0] tx_data_used,
    output logic                        fc_err
);

    fc_req_t [NUM_CLASS-1:0] req;
    logic    [NUM_CLASS-1:0] hdr_viol;
    logic    [NUM_CLASS-1:0] data_viol;
    logic                    any_viol;

    fcc_decode u_dec (
        .valid (dllp_valid),
        .kind  (dllp_kind),
        .cls   (dllp_class),
        .req   (req)
    );

    for (genvar c = 0; c < NUM_CLASS; c++) begin : g_class
        fcc_field #(
            .W       (HDR_W),
            .MIN_EN  (1'b0),
            .MIN_LIM (1)
        ) u_hdr (
            .clk  (clk),
            .rst  (rst),
            .req  (req[c]),
            .adv  (hdr_credit),
            .used (tx_hdr_used[c*HDR_W +: HDR_W]),
            .viol (hdr_viol[c])
        );

        fcc_field #(
            .W       (DATA_W),
            .MIN_EN  (class_has_floor(c)),
            .MIN_LIM (MIN_DATA)
        ) u_data (
            .clk  (clk),
            .rst  (rst),
            .req  (req[c]),
            .adv  (data_credit),
            .used (tx_data_used[c*DATA_W +: DATA_W]),
            .viol (data_viol[c])
        );
    end

    always_comb any_viol = |{hdr_viol, data_viol};

    always_ff @(posedge clk) begin
        if (rst) fc_err <= 1'b0;
        else     fc_err <= any_viol;
    end

endmodule

// File: rtl/fcc_sva.sv
module fcc_sva
    import fcc_pkg::*;
#(
    parameter int DATA_W   = DEF_DATA_W,
    parameter int MIN_DATA = DEF_MIN_DATA
) (
    input logic                        clk,
    input logic                        rst,
    input logic                        dllp_valid,
    input logic [1:0]                  dllp_kind,
    input logic [1:0]                  dllp_class,
    input logic [DATA_W-1:0]           data_credit,
    input logic [NUM_CLASS*DATA_W-1:0] tx_data_used,
    input logic                        fc_err
);

    localparam logic [DATA_W-1:0] HALF = DATA_W'((1 << (DATA_W - 1)) - 1);

    logic init_strobe;
    logic small_data;
    logic [DATA_W-1:0] post_outst;

    always_comb begin
        init_strobe = dllp_valid && ((dllp_kind == 2'b00) || (dllp_kind == 2'b01));
        small_data  = (data_credit != '0) && (data_credit < DATA_W'(MIN_DATA));
        post_outst  = data_credit - tx_data_used[DATA_W-1:0];
    end

    // R1
    p_reset_quiet_r1: assert property (@(posedge clk) rst |=> !fc_err);

    // R8
    p_pulse_follows_strobe_r8: assert property (@(posedge clk) disable iff (rst)
        fc_err |-> $past(dllp_valid));

    p_pulse_one_cycle_r8: assert property (@(posedge clk) disable iff (rst)
        (fc_err && !dllp_valid) |=> !fc_err);

    // R10
    p_kind_ignored_r10: assert property (@(posedge clk) disable iff (rst)
        (dllp_valid && dllp_kind == 2'b11) |=> !fc_err);

    p_class_ignored_r10: assert property (@(posedge clk) disable iff (rst)
        (dllp_valid && dllp_class == 2'b11) |=> !fc_err);

    // R4
    p_post_floor_r4: assert property (@(posedge clk) disable iff (rst)
        (init_strobe && dllp_class == 2'b00 && small_data) |=> fc_err);

    // R5
    p_cpl_floor_r5: assert property (@(posedge clk) disable iff (rst)
        (init_strobe && dllp_class == 2'b10 && small_data) |=> fc_err);

    // R2
    p_post_data_ceiling_r2: assert property (@(posedge clk) disable iff (rst)
        (init_strobe && dllp_class == 2'b00 && data_credit != '0 && post_outst > HALF)
        |=> fc_err);

endmodule

bind fc_credit_checker fcc_sva #(
    .DATA_W   (DATA_W),
    .MIN_DATA (MIN_DATA)
) u_sva (
    .clk          (clk),
    .rst          (rst),
    .dllp_valid   (dllp_valid),
    .dllp_kind    (dllp_kind),
    .dllp_class   (dllp_class),
    .data_credit  (data_credit),
    .tx_data_used (tx_data_used),
    .fc_err       (fc_err)
);

// File: tb/fc_credit_checker_tb.sv
module fc_credit_checker_tb;

    localparam int CLK_PERIOD = 10;
    localparam int HW = 8;
    localparam int DW = 12;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          dllp_valid = 1'b0;
    logic [1:0]    dllp_kind = 2'b00;
    logic [1:0]    dllp_class = 2'b00;
    logic [HW-1:0] hdr_credit = '0;
    logic [DW-1:0] data_credit = '0;
    logic [HW-1:0] uh [3];
    logic [DW-1:0] ud [3];
    logic [3*HW-1:0] tx_hdr_used;
    logic [3*DW-1:0] tx_data_used;
    logic          fc_err;

    int n_tests = 0;
    int n_fail  = 0;
    int cyc     = 0;
    bit running = 1'b0;

    int    q_cyc [$];
    bit    q_exp [$];
    string q_tag [$];

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    assign tx_hdr_used  = {uh[2], uh[1], uh[0]};
    assign tx_data_used = {ud[2], ud[1], ud[0]};

    fc_credit_checker u_dut (
        .clk          (clk),
        .rst          (rst),
        .dllp_valid   (dllp_valid),
        .dllp_kind    (dllp_kind),
        .dllp_class   (dllp_class),
        .hdr_credit   (hdr_credit),
        .data_credit  (data_credit),
        .tx_hdr_used  (tx_hdr_used),
        .tx_data_used (tx_data_used),
        .fc_err       (fc_err)
    );

    task automatic report;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    task automatic compare(input logic act, input bit exp, input string tag);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: fc_err actual=%0b expected=%0b", tag, act, exp);
        end
    endtask

    // driver: one DLLP strobe, expected outcome pushed for the monitor
    task automatic send(input logic [1:0] k, input logic [1:0] c,
                        input int h, input int d, input bit exp, input string tag);
        @(negedge clk);
        dllp_valid  = 1'b1;
        dllp_kind   = k;
        dllp_class  = c;
        hdr_credit  = HW'(h);
        data_credit = DW'(d);
        q_cyc.push_back(cyc);
        q_exp.push_back(exp);
        q_tag.push_back(tag);
        @(negedge clk);
        dllp_valid  = 1'b0;
    endtask

    // monitor: one cycle after each strobe the pulse must match; else quiet
    always @(negedge clk) begin
        if (running && !rst) begin
            if (q_cyc.size() > 0 && q_cyc[0] == cyc - 1) begin
                compare(fc_err, q_exp[0], q_tag[0]);
                void'(q_cyc.pop_front());
                void'(q_exp.pop_front());
                void'(q_tag.pop_front());
            end else if (fc_err !== 1'b0) begin
                compare(fc_err, 1'b0, "R8 pulse without strobe");
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual=hung expected=done");
        report();
    end

    task automatic drain;
        repeat (3) @(negedge clk);
    endtask

    initial begin
        for (int i = 0; i < 3; i++) begin uh[i] = '0; ud[i] = '0; end
        repeat (3) @(negedge clk);
        compare(fc_err, 1'b0, "R1 output low in reset");
        rst = 1'b0;
        @(negedge clk);
        compare(fc_err, 1'b0, "R1 output low after reset");
        running = 1'b1;

        // floors
        send(2'd0, 2'd0, 8, 8,  1'b0, "R4 posted init data 8 legal");
        send(2'd0, 2'd0, 8, 7,  1'b1, "R4 posted init data 7");
        send(2'd1, 2'd0, 8, 1,  1'b1, "R4 posted init2 data 1");
        send(2'd0, 2'd2, 8, 5,  1'b1, "R5 completion init data 5");
        send(2'd0, 2'd2, 8, 8,  1'b0, "R5 completion init data 8 legal");
        send(2'd0, 2'd1, 10, 3, 1'b0, "R6 non-posted init data 3 legal");

        // infinite marking on posted
        send(2'd0, 2'd0, 0, 0,     1'b0, "R7 posted init zero");
        send(2'd2, 2'd0, 200, 3000, 1'b0, "R7 update to infinite posted");
        send(2'd2, 2'd2, 8, 3000,  1'b1, "R9 completion still finite");

        // data ceiling on non-posted
        send(2'd0, 2'd1, 10, 100,  1'b0, "R2 non-posted init 100");
        send(2'd2, 2'd1, 10, 2047, 1'b0, "R2 outstanding 2047 legal");
        send(2'd2, 2'd1, 10, 2048, 1'b1, "R2 outstanding 2048");
        ud[1] = DW'(100);
        send(2'd2, 2'd1, 10, 2147, 1'b0, "R2 2147-100 legal");
        send(2'd2, 2'd1, 10, 2148, 1'b1, "R2 2148-100");
        ud[1] = DW'(4000);
        send(2'd2, 2'd1, 10, 1950, 1'b0, "R2 wrap gives 2046");
        send(2'd2, 2'd1, 10, 1952, 1'b1, "R2 wrap gives 2048");
        ud[1] = '0;

        // header ceiling
        send(2'd2, 2'd1, 127, 50, 1'b0, "R3 header 127 legal");
        send(2'd2, 2'd1, 128, 50, 1'b1, "R3 header 128");
        uh[1] = HW'(250);
        send(2'd2, 2'd1, 100, 50, 1'b0, "R3 header wrap gives 106");
        send(2'd2, 2'd1, 122, 50, 1'b1, "R3 header wrap gives 128");
        uh[1] = '0;

        // ignored codes
        send(2'd3, 2'd0, 8, 5,    1'b0, "R10 kind 3 ignored");
        send(2'd0, 2'd3, 200, 5,  1'b0, "R10 class 3 ignored");

        // reset clears the infinite marking
        drain();
        rst = 1'b1;
        repeat (2) @(negedge clk);
        compare(fc_err, 1'b0, "R1 output low in second reset");
        rst = 1'b0;
        send(2'd2, 2'd0, 8, 3000, 1'b1, "R1 posted limit cleared by reset");
        send(2'd0, 2'd0, 200, 0,  1'b1, "R3 init header 200 ceiling");

        drain();
        if (q_cyc.size() != 0) begin
            n_tests++;
            n_fail++;
            $display("FAIL R8: actual=%0d pending expected=0", q_cyc.size());
        end
        report();
    end

endmodule